// File: doc/BRIEF.md
# Device Configuration Startup Sequencer

This block steps a programmable device from the moment power is applied up to user operation. After a power-on wait, whose length is picked by mode bit 0, it clears the configuration memory. It then waits for the external reset line to go high, latches the three mode pins and enters a configuring phase. A loader reports the end of configuration with a one-cycle strobe. The sequencer then releases the done flag and the output enable in a fixed order, one cycle apart. The order is chosen by a parameter.

Once the device is running, the reset line becomes a global reset for user storage. A falling edge on the done/program pin starts a new configuration. A low power-down input puts the device into a quiet state. When that input returns high, done is held low for a short resume window. The bitstream transfer itself is the loader's job.

Top module: `cfg_startup_seq`

## Requirements
- R1: After `rst` falls, `init_n` stays low and `clear_mem` stays low for 2^POR_SHORT_LOG2 cycles if `mode[0]` was high while `rst` was asserted, and for 2^POR_LONG_LOG2 cycles if it was low. `clear_mem` rises in the next cycle.
- R2: The clear phase keeps `clear_mem` high and `init_n` low for exactly CLEAR_CYCLES cycles. Then both are released.
- R3: After the clear phase the sequencer waits as long as the synchronised `reset_n` is low. The configuring phase begins 3 cycles after `reset_n` is driven high.
- R4: `mode_sampled` takes the value of `mode[2:0]` only in the cycle the configuring phase begins. At all other times it holds its value.
- R5: `hdc` is high and `ldc` is low in every phase before user operation. In the user, power-down and resume phases, `hdc` is low and `ldc` is high.
- R6: `reset_n` low during configuring re-enters the clear phase 3 cycles later and does not raise `global_reset`. Configuring restarts 3 cycles after `reset_n` returns high.
- R7: A `config_complete` strobe during configuring gives one startup cycle. With DONE_BEFORE_OE=1, `done` is high and `outputs_enable` is low in that cycle; with 0, the reverse holds. Both are high in the next cycle.
- R8: In user operation, `reset_n` low raises `global_reset` in the same cycle, combinationally, and leaves the phase unchanged.
- R9: In user operation, a high-to-low edge on `done_prog_in` enters the clear phase 3 cycles later, with `done` low.
- R10: 3 cycles after `pwrdwn_n` goes low in user operation, `outputs_enable` and `done` are low and `inputs_force_high` and `global_reset` are high.
- R11: 3 cycles after `pwrdwn_n` returns high, `outputs_enable` is high and `done` stays low for RESUME_CYCLES (2) cycles. Then `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high power-applied reset |
| reset_n | input | 1 | External reset line, active low |
| pwrdwn_n | input | 1 | Power-down request, active low |
| done_prog_in | input | 1 | Level sensed on the done/program pin |
| mode | input | 3 | Mode pins; bit 0 also picks the power-on wait |
| config_complete | input | 1 | One-cycle strobe from the loader |
| mode_sampled | output | 3 | Mode latched at the start of configuring |
| done | output | 1 | Configuration done flag |
| init_n | output | 1 | Low during power-on wait and memory clear |
| hdc | output | 1 | High while not yet in user operation |
| ldc | output | 1 | Low while not yet in user operation |
| outputs_enable | output | 1 | User outputs enabled |
| inputs_force_high | output | 1 | User inputs forced to read high |
| global_reset | output | 1 | Reset to all user storage |
| clear_mem | output | 1 | Configuration memory clear in progress |

## Verification
Each result has a fixed latency:
- A `config_complete` strobe shows on the outputs 1 cycle later.
- `reset_n`, `pwrdwn_n` and `done_prog_in` pass through two synchroniser flops and the phase register, so their effects show 3 cycles after the input changes.
- The user-phase `global_reset` follows `reset_n` within the same cycle.

Each stimulus task pushes its expected output snapshots onto a scoreboard, each tagged with the exact cycle it is due. A monitor samples on the falling clock edge and compares each item in its due cycle. An item found past its due cycle counts as a failure, so early or late changes are caught as well as wrong values.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    S_POR,
    S_CLEAR,
    S_HOLD,
    S_CONFIG,
    S_START,
    S_USER,
    S_PWRDN,
    S_RESUME
  } seq_state_e;

  typedef struct packed {
    logic done;
    logic init_n;
    logic hdc;
    logic ldc;
    logic oe;
    logic force_hi;
    logic grst;
    logic clr;
    logic user;
  } seq_out_t;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int                 WIDTH   = 1,
  parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] limit_m1,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit_m1);

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int POR_SHORT_LOG2 = 14,
  parameter int POR_LONG_LOG2  = 16,
  parameter int CLEAR_CYCLES   = 8,
  parameter int RESUME_CYCLES  = 2,
  parameter bit DONE_BEFORE_OE = 1'b1,
  parameter int W              = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rst_n_s,
  input  logic         pwr_ok_s,
  input  logic         prog_fall,
  input  logic         cfg_done,
  input  logic [2:0]   mode_i,
  input  logic         expired,
  output logic         restart,
  output logic [W-1:0] limit_m1,
  output logic [2:0]   mode_q,
  output seq_out_t     outs_q
);

  localparam logic [W-1:0] LIM_SHORT  = W'((64'd1 << POR_SHORT_LOG2) - 64'd1);
  localparam logic [W-1:0] LIM_LONG   = W'((64'd1 << POR_LONG_LOG2) - 64'd1);
  localparam logic [W-1:0] LIM_CLEAR  = W'(CLEAR_CYCLES - 1);
  localparam logic [W-1:0] LIM_RESUME = W'(RESUME_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic       long_wait;

  function automatic seq_out_t decode(input seq_state_e s);
    seq_out_t o;
    o        = '0;
    o.hdc    = 1'b1;
    o.init_n = 1'b1;
    case (s)
      S_POR:   o.init_n = 1'b0;
      S_CLEAR: begin
        o.init_n = 1'b0;
        o.clr    = 1'b1;
      end
      S_START: begin
        o.done = DONE_BEFORE_OE;
        o.oe   = !DONE_BEFORE_OE;
        o.user = 1'b1;
      end
      S_USER: begin
        o.done = 1'b1;
        o.oe   = 1'b1;
        o.hdc  = 1'b0;
        o.ldc  = 1'b1;
        o.user = 1'b1;
      end
      S_PWRDN: begin
        o.hdc      = 1'b0;
        o.ldc      = 1'b1;
        o.force_hi = 1'b1;
        o.grst     = 1'b1;
      end
      S_RESUME: begin
        o.oe   = 1'b1;
        o.hdc  = 1'b0;
        o.ldc  = 1'b1;
        o.user = 1'b1;
      end
      default: ;
    endcase
    return o;
  endfunction

  // power-on wait length is latched from mode bit 0 while rst is held
  always_ff @(posedge clk) begin
    if (rst) long_wait <= !mode_i[0];
  end

  always_comb begin
    case (state_q)
      S_POR:    limit_m1 = long_wait ? LIM_LONG : LIM_SHORT;
      S_CLEAR:  limit_m1 = LIM_CLEAR;
      S_RESUME: limit_m1 = LIM_RESUME;
      default:  limit_m1 = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_POR:    if (expired) state_d = S_CLEAR;
      S_CLEAR:  if (expired) state_d = S_HOLD;
      S_HOLD:   if (rst_n_s) state_d = S_CONFIG;
      S_CONFIG: begin
        if (!rst_n_s)      state_d = S_CLEAR;
        else if (cfg_done) state_d = S_START;
      end
      S_START:  state_d = S_USER;
      S_USER: begin
        if (!pwr_ok_s)      state_d = S_PWRDN;
        else if (prog_fall) state_d = S_CLEAR;
      end
      S_PWRDN:  if (pwr_ok_s) state_d = S_RESUME;
      S_RESUME: begin
        if (!pwr_ok_s)      state_d = S_PWRDN;
        else if (prog_fall) state_d = S_CLEAR;
        else if (expired)   state_d = S_USER;
      end
      default:  state_d = S_POR;
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_POR;
      outs_q  <= decode(S_POR);
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      outs_q  <= decode(state_d);
      if (state_q == S_HOLD && state_d == S_CONFIG) mode_q <= mode_i;
    end
  end

  a_r1_init_low_in_por: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_POR) |-> !outs_q.init_n);

  a_r3_hold_while_reset: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HOLD && !rst_n_s) |=> (state_q == S_HOLD));

  a_r4_mode_stable: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_HOLD) |=> $stable(mode_q));

  a_r6_reinit_in_config: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CONFIG && !rst_n_s) |=> (state_q == S_CLEAR && outs_q.clr));

  a_r7_startup_order: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_USER && $past(state_q) == S_START) |->
      ($past(outs_q.done) == DONE_BEFORE_OE && $past(outs_q.oe) != DONE_BEFORE_OE));

  a_r10_pwrdn_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_PWRDN) |-> (!outs_q.oe && !outs_q.done && outs_q.force_hi && outs_q.grst));

  a_r11_resume_done_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RESUME) |-> (!outs_q.done && outs_q.oe));

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_seq_pkg::*;
#(
  parameter int POR_SHORT_LOG2 = 14,
  parameter int POR_LONG_LOG2  = 16,
  parameter int CLEAR_CYCLES   = 8,
  parameter int RESUME_CYCLES  = 2,
  parameter bit DONE_BEFORE_OE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reset_n,
  input  logic       pwrdwn_n,
  input  logic       done_prog_in,
  input  logic [2:0] mode,
  input  logic       config_complete,
  output logic [2:0] mode_sampled,
  output logic       done,
  output logic       init_n,
  output logic       hdc,
  output logic       ldc,
  output logic       outputs_enable,
  output logic       inputs_force_high,
  output logic       global_reset,
  output logic       clear_mem
);

  localparam int PW  = (POR_LONG_LOG2 > POR_SHORT_LOG2) ? POR_LONG_LOG2 : POR_SHORT_LOG2;
  localparam int CLW = $clog2(CLEAR_CYCLES + 1);
  localparam int RSW = $clog2(RESUME_CYCLES + 1);
  localparam int W0  = (PW > CLW) ? PW : CLW;
  localparam int W   = (W0 > RSW) ? W0 : RSW;

  logic [2:0]   pins_s;
  logic         rst_n_s, pwr_ok_s, prog_s, prog_d, prog_fall;
  logic         restart, expired;
  logic [W-1:0] limit_m1;
  seq_out_t     outs;

  cfg_sync2 #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({reset_n, pwrdwn_n, done_prog_in}),
    .q   (pins_s)
  );

  assign rst_n_s  = pins_s[2];
  assign pwr_ok_s = pins_s[1];
  assign prog_s   = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) prog_d <= 1'b1;
    else     prog_d <= prog_s;
  end

  assign prog_fall = prog_d & ~prog_s;

  cfg_phase_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .limit_m1 (limit_m1),
    .expired  (expired)
  );

  cfg_seq_fsm #(
    .POR_SHORT_LOG2 (POR_SHORT_LOG2),
    .POR_LONG_LOG2  (POR_LONG_LOG2),
    .CLEAR_CYCLES   (CLEAR_CYCLES),
    .RESUME_CYCLES  (RESUME_CYCLES),
    .DONE_BEFORE_OE (DONE_BEFORE_OE),
    .W              (W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .rst_n_s   (rst_n_s),
    .pwr_ok_s  (pwr_ok_s),
    .prog_fall (prog_fall),
    .cfg_done  (config_complete),
    .mode_i    (mode),
    .expired   (expired),
    .restart   (restart),
    .limit_m1  (limit_m1),
    .mode_q    (mode_sampled),
    .outs_q    (outs)
  );

  assign done              = outs.done;
  assign init_n            = outs.init_n;
  assign hdc               = outs.hdc;
  assign ldc               = outs.ldc;
  assign outputs_enable    = outs.oe;
  assign inputs_force_high = outs.force_hi;
  assign clear_mem         = outs.clr;
  // user-phase reset acts without waiting for a clock edge (R8)
  assign global_reset      = outs.grst | (outs.user & ~reset_n);

endmodule

// File: tb/cfg_startup_seq_test.sv
module cfg_startup_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 3000;

  typedef struct {
    int          at;
    string       req;
    logic [12:0] exp;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst, reset_n, pwrdwn_n, done_prog_in, config_complete;
  logic [2:0] mode;
  logic [2:0] m_mode, m2_mode;
  logic       m_done, m_init, m_hdc, m_ldc, m_oe, m_frc, m_grst, m_clr;
  logic       m2_done, m2_init, m2_hdc, m2_ldc, m2_oe, m2_frc, m2_grst, m2_clr;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;
  sb_item_t   sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_startup_seq #(.POR_SHORT_LOG2(4), .POR_LONG_LOG2(5), .CLEAR_CYCLES(4),
                    .RESUME_CYCLES(2), .DONE_BEFORE_OE(1'b1)) uut (
    .clk(clk), .rst(rst), .reset_n(reset_n), .pwrdwn_n(pwrdwn_n),
    .done_prog_in(done_prog_in), .mode(mode), .config_complete(config_complete),
    .mode_sampled(m_mode), .done(m_done), .init_n(m_init), .hdc(m_hdc), .ldc(m_ldc),
    .outputs_enable(m_oe), .inputs_force_high(m_frc), .global_reset(m_grst),
    .clear_mem(m_clr));

  cfg_startup_seq #(.POR_SHORT_LOG2(4), .POR_LONG_LOG2(5), .CLEAR_CYCLES(4),
                    .RESUME_CYCLES(2), .DONE_BEFORE_OE(1'b0)) uut_late (
    .clk(clk), .rst(rst), .reset_n(reset_n), .pwrdwn_n(pwrdwn_n),
    .done_prog_in(done_prog_in), .mode(mode), .config_complete(config_complete),
    .mode_sampled(m2_mode), .done(m2_done), .init_n(m2_init), .hdc(m2_hdc), .ldc(m2_ldc),
    .outputs_enable(m2_oe), .inputs_force_high(m2_frc), .global_reset(m2_grst),
    .clear_mem(m2_clr));

  // snapshot: {mode[2:0], done, init_n, hdc, ldc, oe, force, greset, clr, done2, oe2}
  function automatic logic [12:0] snap();
    return {m_mode, m_done, m_init, m_hdc, m_ldc, m_oe, m_frc, m_grst, m_clr, m2_done, m2_oe};
  endfunction

  function automatic logic [12:0] vv(input logic [2:0] md, input logic dn, it, hd, ld,
                                     oe, fr, gr, cl, d2, o2);
    return {md, dn, it, hd, ld, oe, fr, gr, cl, d2, o2};
  endfunction

  function automatic logic [12:0] v_por(input logic [2:0] md); return vv(md,0,0,1,0,0,0,0,0,0,0); endfunction
  function automatic logic [12:0] v_clr(input logic [2:0] md); return vv(md,0,0,1,0,0,0,0,1,0,0); endfunction
  function automatic logic [12:0] v_hld(input logic [2:0] md); return vv(md,0,1,1,0,0,0,0,0,0,0); endfunction
  function automatic logic [12:0] v_st (input logic [2:0] md); return vv(md,1,1,1,0,0,0,0,0,0,1); endfunction
  function automatic logic [12:0] v_usr(input logic [2:0] md, input logic gr);
    return vv(md,1,1,0,1,1,0,gr,0,1,1);
  endfunction
  function automatic logic [12:0] v_pwd(input logic [2:0] md); return vv(md,0,1,0,1,0,1,1,0,0,0); endfunction
  function automatic logic [12:0] v_rsm(input logic [2:0] md); return vv(md,0,1,0,1,1,0,0,0,0,1); endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_at(input int delta, input string req, input logic [12:0] e);
    sb_item_t it;
    it.at  = cyc + delta;
    it.req = req;
    it.exp = e;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      sb_item_t it;
      it = sb.pop_front();
      checks++;
      if (it.at != cyc || snap() !== it.exp) begin
        errors++;
        $display("FAIL %s cycle %0d (due %0d): actual=%b expected=%b",
                 it.req, cyc, it.at, snap(), it.exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == WATCHDOG && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=cycle %0d expected=finish before it", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reset_n = 1'b0; pwrdwn_n = 1'b1; done_prog_in = 1'b1;
    mode = 3'b001; config_complete = 1'b0;
    step(3);
    expect_at(0, "R1", v_por(3'b000));           // reset state

    // short power-on wait (mode[0]=1), clear phase, hold while reset_n low
    rst = 1'b0;
    expect_at(15, "R1", v_por(3'b000));
    expect_at(16, "R1", v_clr(3'b000));
    expect_at(19, "R2", v_clr(3'b000));
    expect_at(20, "R2", v_hld(3'b000));
    expect_at(30, "R3", v_hld(3'b000));
    step(30);
    reset_n = 1'b1; mode = 3'b101;
    expect_at(2, "R4", v_hld(3'b000));
    expect_at(3, "R3", v_hld(3'b101));            // configuring, mode latched
    step(5);
    mode = 3'b010;
    expect_at(3, "R4", v_hld(3'b101));            // mode change ignored
    step(4);

    // reset during configuring
    reset_n = 1'b0;
    expect_at(0, "R6", v_hld(3'b101));            // no global reset
    expect_at(3, "R6", v_clr(3'b101));
    expect_at(7, "R6", v_hld(3'b101));
    step(10);
    reset_n = 1'b1;
    expect_at(3, "R6", v_hld(3'b010));
    step(4);

    // startup ordering (uut: done first, uut_late: outputs first)
    expect_at(1, "R7", v_st(3'b010));
    expect_at(2, "R5", v_usr(3'b010, 1'b0));
    config_complete = 1'b1;
    step(1);
    config_complete = 1'b0;
    step(2);

    // user-phase reset
    reset_n = 1'b0;
    expect_at(0, "R8", v_usr(3'b010, 1'b1));
    expect_at(4, "R8", v_usr(3'b010, 1'b1));
    step(5);
    reset_n = 1'b1;
    expect_at(0, "R8", v_usr(3'b010, 1'b0));
    step(4);

    // power-down and resume
    pwrdwn_n = 1'b0;
    expect_at(2, "R10", v_usr(3'b010, 1'b0));
    expect_at(3, "R10", v_pwd(3'b010));
    step(6);
    pwrdwn_n = 1'b1;
    expect_at(2, "R11", v_pwd(3'b010));
    expect_at(3, "R11", v_rsm(3'b010));
    expect_at(4, "R11", v_rsm(3'b010));
    expect_at(5, "R11", v_usr(3'b010, 1'b0));
    step(8);

    // program-pin falling edge restarts configuration
    done_prog_in = 1'b0; mode = 3'b110;
    expect_at(2, "R9", v_usr(3'b010, 1'b0));
    expect_at(3, "R9", v_clr(3'b010));
    expect_at(7, "R9", v_hld(3'b010));
    expect_at(8, "R4", v_hld(3'b110));
    step(4);
    done_prog_in = 1'b1;
    step(8);

    // long power-on wait (mode[0]=0)
    rst = 1'b1; mode = 3'b000;
    step(3);
    rst = 1'b0;
    expect_at(31, "R1", v_por(3'b000));
    expect_at(32, "R1", v_clr(3'b000));
    step(40);

    while (sb.size() > 0) step(1);
    step(2);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule